// File: doc/BRIEF.md
# Timed Multichannel Scan Sequencer

This block drives a timed acquisition over a programmable list of conversion slots. Each slot of the list holds one channel number and one gain range code. Two timers set the pace. The convert timer sets the spacing between individual conversions. The scan timer sets the spacing between the starts of scans. Each timer counts strobes of its own base tick. The surrounding logic supplies the convert base strobe at 50 ns and the scan base strobe at 100 ns. Each timer takes a packed configuration word. The 4-bit prescale sits in bits 19:16 and the 16-bit divider sits in bits 15:0.

A run begins with an accepted `go` and ends when the programmed sample total has been emitted or when `abort` is raised. For every conversion the block presents a slot index, a channel number and a range code for one cycle to the converter that follows it. The converter itself is not part of the block. The trigger mode is sampled at `go`. It selects among these behaviours:
- the first scan starts at once or waits for an external start pulse;
- scans run back to back, or each scan waits for the scan timer or for an external pulse.

Top module: `scan_sequencer`

## Requirements
- R1: After reset `busy`, `smp_valid`, `done` and `overrun` are all 0.
- R2: A list slot is 8 bits, laid out as the range code in bits 7:6 and the channel in bits 5:0. Each emitted sample shows on `smp_chan` and `smp_range` the fields of the slot named by `smp_idx`.
- R3: A timer word holds the prescale P in bits 19:16 and the divider D in bits 15:0. Its period is (P+1)×D strobes of its base strobe. Inside a run, after the first sample of a convert sequence, consecutive samples are exactly one convert period apart.
- R4: A divider field of 0 counts as 65536.
- R5: Mode 0 (internal): the first sample, slot 0, appears on the cycle after `go` is accepted. Slots then follow in order on convert ticks, and the list wraps from the last slot to slot 0 with no pause.
- R6: Mode 2 (internal retrigger): the first scan starts at `go`. Every later scan starts on a scan timer tick. Each scan emits slot 0 at its start, emits the remaining slots on convert ticks, and then waits. Scan starts after the first are exactly one scan period apart.
- R7: Modes 1, 3 and 4 wait after `go` for an `ext_trig` pulse before the first sample. Mode 1 then behaves as mode 0 and mode 3 behaves as mode 2. In mode 4 each scan starts on an `ext_trig` pulse. A `go` with mode codes 5 to 7 is ignored.
- R8: In modes 2, 3 and 4, a scan start event that arrives while a scan is still emitting sets `overrun`. `overrun` stays set until the next accepted `go` clears it.
- R9: With a nonzero 24-bit `stop_count` N, the Nth sample carries a one-cycle `done`, and `busy` is 0 from that cycle on. With N = 0 the run continues until `abort`.
- R10: `abort` returns the block to idle on the next cycle. No further sample and no `done` are produced.
- R11: `go` is ignored while `busy` is 1.
- R12: A `scan_len` of 0 is treated as 1, and a value above the list depth is treated as the depth. `smp_idx` never reaches the effective length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| list_we | input | 1 | Write strobe for the slot list |
| list_waddr | input | 9 | Slot index to write |
| list_wdata | input | 8 | Slot value, range in 7:6, channel in 5:0 |
| scan_len | input | 10 | Slots per scan |
| trig_mode | input | 3 | Trigger mode code 0 to 4 |
| conv_word | input | 20 | Convert timer word (prescale 19:16, divider 15:0) |
| scan_word | input | 20 | Scan timer word (prescale 19:16, divider 15:0) |
| stop_count | input | 24 | Total samples per run, 0 for unbounded |
| go | input | 1 | Start request |
| abort | input | 1 | Stop the run at once |
| ext_trig | input | 1 | External trigger pulse |
| conv_base_stb | input | 1 | Convert base strobe (50 ns tick) |
| scan_base_stb | input | 1 | Scan base strobe (100 ns tick) |
| busy | output | 1 | A run is in progress |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_chan | output | 6 | Channel of the sample |
| smp_range | output | 2 | Range code of the sample |
| smp_idx | output | 9 | Slot index of the sample |
| done | output | 1 | One-cycle end-of-run pulse |
| overrun | output | 1 | Sticky scan overrun flag |

## Verification
A wrong slot position shows on `smp_idx` at the next sample strobe, as a slot out of order or a missing wrap. A wrong sample count shows as a `done` that comes early or late, and a wrong state shows as samples appearing while the block should be waiting for a trigger. A timer counter that is off by one shows as a sample spacing different from (P+1)×D base strobes within a single period. A stuck or dropped overrun flag shows as soon as a scan start lands inside a running scan.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_SCAN = 2'd2,
        ST_WAIT = 2'd3
    } seq_state_e;

    localparam logic [2:0] TM_INT        = 3'd0;
    localparam logic [2:0] TM_EXT        = 3'd1;
    localparam logic [2:0] TM_INT_RETRIG = 3'd2;
    localparam logic [2:0] TM_EXT_RETRIG = 3'd3;
    localparam logic [2:0] TM_EXT_EACH   = 3'd4;

    function automatic logic mode_ok(input logic [2:0] m);
        return m <= TM_EXT_EACH;
    endfunction

    function automatic logic ext_start(input logic [2:0] m);
        return (m == TM_EXT) || (m == TM_EXT_RETRIG) || (m == TM_EXT_EACH);
    endfunction

    function automatic logic retrig(input logic [2:0] m);
        return (m == TM_INT_RETRIG) || (m == TM_EXT_RETRIG) || (m == TM_EXT_EACH);
    endfunction

endpackage

// File: rtl/scan_seq_chanlist.sv
module scan_seq_chanlist #(
    parameter int DEPTH = 512,
    parameter int ENT_W = 8,
    parameter int AW    = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [ENT_W-1:0] rdata
);
    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/scan_seq_timer.sv
module scan_seq_timer #(
    parameter int PRE_W = 4,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic             base_stb,
    input  logic [PRE_W-1:0] pre,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] pre_cnt;
        logic [DIV_W-1:0] div_cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [DIV_W-1:0] div_last;
    logic pre_wrap, div_wrap;

    // Divider 0 wraps to all ones, giving a full 2**DIV_W count.
    assign div_last = div - DIV_W'(1);
    assign pre_wrap = (tmr_q.pre_cnt == pre);
    assign div_wrap = (tmr_q.div_cnt == div_last);
    assign tick     = run && base_stb && pre_wrap && div_wrap;

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d = '0;
        end else if (run && base_stb) begin
            if (pre_wrap) begin
                tmr_d.pre_cnt = '0;
                tmr_d.div_cnt = div_wrap ? '0 : tmr_q.div_cnt + DIV_W'(1);
            end else begin
                tmr_d.pre_cnt = tmr_q.pre_cnt + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int LIST_DEPTH = 512,
    parameter int CH_W       = 6,
    parameter int RNG_W      = 2,
    parameter int COUNT_W    = 24,
    parameter int WORD_W     = 20,
    localparam int IDX_W     = $clog2(LIST_DEPTH),
    localparam int LEN_W     = $clog2(LIST_DEPTH + 1),
    localparam int ENT_W     = CH_W + RNG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic               abort,
    input  logic               ext_trig,
    input  logic [2:0]         trig_mode,
    input  logic [LEN_W-1:0]   scan_len,
    input  logic [COUNT_W-1:0] stop_count,
    input  logic [WORD_W-1:0]  conv_word,
    input  logic [WORD_W-1:0]  scan_word,
    input  logic               conv_tick,
    input  logic               scan_tick,
    input  logic [ENT_W-1:0]   rd_entry,
    output logic [IDX_W-1:0]   rd_addr,
    output logic               conv_restart,
    output logic               conv_run,
    output logic               scan_restart,
    output logic               scan_run,
    output logic [WORD_W-1:0]  conv_word_q,
    output logic [WORD_W-1:0]  scan_word_q,
    output logic               busy,
    output logic               smp_valid,
    output logic [CH_W-1:0]    smp_chan,
    output logic [RNG_W-1:0]   smp_range,
    output logic [IDX_W-1:0]   smp_idx,
    output logic               done,
    output logic               overrun
);
    typedef struct packed {
        seq_state_e         state;
        logic [2:0]         mode;
        logic [IDX_W-1:0]   last;
        logic [IDX_W-1:0]   idx;
        logic [COUNT_W-1:0] stop;
        logic [COUNT_W-1:0] cnt;
        logic [WORD_W-1:0]  cw;
        logic [WORD_W-1:0]  sw;
        logic               valid;
        logic               done;
        logic               overrun;
        logic [CH_W-1:0]    chan;
        logic [RNG_W-1:0]   rng;
    } ctrl_t;

    ctrl_t seq_d, seq_q;
    logic start_scan, first_scan, emit, scan_evt;
    logic [IDX_W-1:0] nidx;

    function automatic logic [IDX_W-1:0] last_of(input logic [LEN_W-1:0] len);
        if (len == '0)                          return '0;
        else if (len > LEN_W'(LIST_DEPTH))      return IDX_W'(LIST_DEPTH - 1);
        else                                    return IDX_W'(len - LEN_W'(1));
    endfunction

    always_comb begin
        seq_d       = seq_q;
        seq_d.valid = 1'b0;
        seq_d.done  = 1'b0;
        start_scan  = 1'b0;
        first_scan  = 1'b0;
        emit        = 1'b0;
        nidx        = '0;
        scan_evt    = (seq_q.mode == TM_EXT_EACH) ? ext_trig : scan_tick;

        case (seq_q.state)
            ST_IDLE: begin
                if (go && mode_ok(trig_mode)) begin
                    seq_d.mode    = trig_mode;
                    seq_d.last    = last_of(scan_len);
                    seq_d.stop    = stop_count;
                    seq_d.cnt     = '0;
                    seq_d.overrun = 1'b0;
                    seq_d.cw      = conv_word;
                    seq_d.sw      = scan_word;
                    if (ext_start(trig_mode)) begin
                        seq_d.state = ST_ARM;
                    end else begin
                        start_scan = 1'b1;
                        first_scan = 1'b1;
                    end
                end
            end
            ST_ARM: begin
                if (ext_trig) begin
                    start_scan = 1'b1;
                    first_scan = 1'b1;
                end
            end
            ST_SCAN: begin
                if (retrig(seq_q.mode) && scan_evt) seq_d.overrun = 1'b1;
                if (conv_tick) begin
                    emit = 1'b1;
                    nidx = (seq_q.idx == seq_q.last) ? '0 : seq_q.idx + IDX_W'(1);
                end
            end
            ST_WAIT: begin
                if (scan_evt) start_scan = 1'b1;
            end
            default: seq_d.state = ST_IDLE;
        endcase

        if (start_scan) begin
            emit = 1'b1;
            nidx = '0;
        end

        if (emit) begin
            seq_d.valid = 1'b1;
            seq_d.idx   = nidx;
            seq_d.chan  = rd_entry[CH_W-1:0];
            seq_d.rng   = rd_entry[ENT_W-1:CH_W];
            seq_d.cnt   = seq_d.cnt + COUNT_W'(1);
            seq_d.state = (retrig(seq_d.mode) && (nidx == seq_d.last)) ? ST_WAIT : ST_SCAN;
            if ((seq_d.stop != '0) && (seq_d.cnt == seq_d.stop)) begin
                seq_d.done  = 1'b1;
                seq_d.state = ST_IDLE;
            end
        end

        if (abort) begin
            seq_d.state = ST_IDLE;
            seq_d.valid = 1'b0;
            seq_d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign rd_addr      = nidx;
    assign conv_restart = start_scan;
    assign conv_run     = (seq_q.state == ST_SCAN);
    assign scan_restart = first_scan;
    assign scan_run     = (seq_q.state == ST_SCAN) || (seq_q.state == ST_WAIT);
    assign conv_word_q  = seq_q.cw;
    assign scan_word_q  = seq_q.sw;
    assign busy         = (seq_q.state != ST_IDLE);
    assign smp_valid    = seq_q.valid;
    assign smp_chan     = seq_q.chan;
    assign smp_range    = seq_q.rng;
    assign smp_idx      = seq_q.idx;
    assign done         = seq_q.done;
    assign overrun      = seq_q.overrun;
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
    parameter int LIST_DEPTH = 512,
    parameter int CH_W       = 6,
    parameter int RNG_W      = 2,
    parameter int COUNT_W    = 24,
    parameter int PRE_W      = 4,
    parameter int DIV_W      = 16,
    localparam int IDX_W     = $clog2(LIST_DEPTH),
    localparam int LEN_W     = $clog2(LIST_DEPTH + 1),
    localparam int ENT_W     = CH_W + RNG_W,
    localparam int WORD_W    = PRE_W + DIV_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               list_we,
    input  logic [IDX_W-1:0]   list_waddr,
    input  logic [ENT_W-1:0]   list_wdata,
    input  logic [LEN_W-1:0]   scan_len,
    input  logic [2:0]         trig_mode,
    input  logic [WORD_W-1:0]  conv_word,
    input  logic [WORD_W-1:0]  scan_word,
    input  logic [COUNT_W-1:0] stop_count,
    input  logic               go,
    input  logic               abort,
    input  logic               ext_trig,
    input  logic               conv_base_stb,
    input  logic               scan_base_stb,
    output logic               busy,
    output logic               smp_valid,
    output logic [CH_W-1:0]    smp_chan,
    output logic [RNG_W-1:0]   smp_range,
    output logic [IDX_W-1:0]   smp_idx,
    output logic               done,
    output logic               overrun
);
    localparam int N_TMR = 2;   // index 0: convert, index 1: scan

    logic [IDX_W-1:0]  rd_addr;
    logic [ENT_W-1:0]  rd_entry;
    logic [N_TMR-1:0]  t_restart, t_run, t_stb, t_tick;
    logic [WORD_W-1:0] t_word [N_TMR];

    assign t_stb = {scan_base_stb, conv_base_stb};

    scan_seq_chanlist #(.DEPTH(LIST_DEPTH), .ENT_W(ENT_W), .AW(IDX_W)) i_list (
        .clk   (clk),
        .we    (list_we),
        .waddr (list_waddr),
        .wdata (list_wdata),
        .raddr (rd_addr),
        .rdata (rd_entry)
    );

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        scan_seq_timer #(.PRE_W(PRE_W), .DIV_W(DIV_W)) i_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (t_restart[g]),
            .run      (t_run[g]),
            .base_stb (t_stb[g]),
            .pre      (t_word[g][WORD_W-1:DIV_W]),
            .div      (t_word[g][DIV_W-1:0]),
            .tick     (t_tick[g])
        );
    end

    scan_seq_ctrl #(
        .LIST_DEPTH (LIST_DEPTH),
        .CH_W       (CH_W),
        .RNG_W      (RNG_W),
        .COUNT_W    (COUNT_W),
        .WORD_W     (WORD_W)
    ) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .abort        (abort),
        .ext_trig     (ext_trig),
        .trig_mode    (trig_mode),
        .scan_len     (scan_len),
        .stop_count   (stop_count),
        .conv_word    (conv_word),
        .scan_word    (scan_word),
        .conv_tick    (t_tick[0]),
        .scan_tick    (t_tick[1]),
        .rd_entry     (rd_entry),
        .rd_addr      (rd_addr),
        .conv_restart (t_restart[0]),
        .conv_run     (t_run[0]),
        .scan_restart (t_restart[1]),
        .scan_run     (t_run[1]),
        .conv_word_q  (t_word[0]),
        .scan_word_q  (t_word[1]),
        .busy         (busy),
        .smp_valid    (smp_valid),
        .smp_chan     (smp_chan),
        .smp_range    (smp_range),
        .smp_idx      (smp_idx),
        .done         (done),
        .overrun      (overrun)
    );
endmodule

// File: rtl/scan_sequencer_checker.sv
module scan_sequencer_checker #(
    parameter int LIST_DEPTH = 512,
    localparam int IDX_W     = $clog2(LIST_DEPTH),
    localparam int LEN_W     = $clog2(LIST_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic             abort,
    input logic             busy,
    input logic             smp_valid,
    input logic             done,
    input logic             overrun,
    input logic [IDX_W-1:0] smp_idx,
    input logic [LEN_W-1:0] scan_len
);
    logic [LEN_W-1:0] eff_len;
    assign eff_len = (scan_len == '0) ? LEN_W'(1) :
                     (scan_len > LEN_W'(LIST_DEPTH)) ? LEN_W'(LIST_DEPTH) : scan_len;

    assert_done_with_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> smp_valid);

    assert_done_ends_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_sample_inside_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !done) |-> busy);

    assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !smp_valid && !done));

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !go) |=> overrun);

    assert_idx_in_scan_R12: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ({1'b0, smp_idx} < eff_len));
endmodule

bind scan_sequencer scan_sequencer_checker #(.LIST_DEPTH(LIST_DEPTH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .abort     (abort),
    .busy      (busy),
    .smp_valid (smp_valid),
    .done      (done),
    .overrun   (overrun),
    .smp_idx   (smp_idx),
    .scan_len  (scan_len)
);

// File: tb/test_scan_sequencer.sv
`timescale 1ns/1ps
module test_scan_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        list_we = 1'b0;
    logic [8:0]  list_waddr = '0;
    logic [7:0]  list_wdata = '0;
    logic [9:0]  scan_len = 10'd1;
    logic [2:0]  trig_mode = 3'd0;
    logic [19:0] conv_word = 20'h00001;
    logic [19:0] scan_word = 20'h00001;
    logic [23:0] stop_count = '0;
    logic        go = 1'b0, abort = 1'b0, ext_trig = 1'b0;
    logic        conv_base_stb = 1'b0, scan_base_stb = 1'b0;
    logic        busy, smp_valid, done, overrun;
    logic [5:0]  smp_chan;
    logic [1:0]  smp_range;
    logic [8:0]  smp_idx;

    scan_sequencer i_scan_sequencer (.*);

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0, failures = 0;
    int cyc = 0, n_s = 0, n_done = 0;
    int conv_sp = 2;
    int   s_cyc [256];
    int   s_idx [256];
    int   s_ch  [256];
    int   s_rg  [256];
    bit   s_dn  [256];
    logic [7:0] ent [4] = '{8'hC5, 8'h4A, 8'h3F, 8'h81};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // base strobes: convert every conv_sp cycles, scan every 4 cycles
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            conv_base_stb = ((ph % conv_sp) == 0);
            scan_base_stb = ((ph % 4) == 0);
            ph++;
        end
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (done) n_done <= n_done + 1;
        if (smp_valid && n_s < 256) begin
            s_cyc[n_s] <= cyc;
            s_idx[n_s] <= int'(smp_idx);
            s_ch[n_s]  <= int'(smp_chan);
            s_rg[n_s]  <= int'(smp_range);
            s_dn[n_s]  <= done;
            n_s <= n_s + 1;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_go();
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
    endtask

    task automatic pulse_ext();
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
    endtask

    task automatic wait_n(input int base, input int n, input int limit, input string req);
        int k = 0;
        while ((n_s - base) < n && k < limit) begin
            @(negedge clk);
            k++;
        end
        chk((n_s - base) >= n, {req, " watchdog"}, n_s - base, n);
        idle(2);
    endtask

    task automatic setup(input logic [2:0] m, input logic [9:0] len, input logic [19:0] cw,
                         input logic [19:0] sw, input logic [23:0] stop);
        trig_mode = m; scan_len = len; conv_word = cw; scan_word = sw; stop_count = stop;
    endtask

    task automatic t_reset();
        chk(!busy && !smp_valid && !done && !overrun, "R1 reset",
            int'({busy, smp_valid, done, overrun}), 0);
    endtask

    task automatic t_mode0();
        int b = n_s;
        int d0 = n_done;
        setup(3'd0, 10'd3, {4'd1, 16'd3}, 20'h00001, 24'd7);
        pulse_go();
        wait_n(b, 7, 600, "R5");
        idle(10);
        chk(n_s - b == 7, "R9 sample total", n_s - b, 7);
        for (int i = 0; i < 7; i++) begin
            chk(s_idx[b+i] == i % 3, "R5 slot order", s_idx[b+i], i % 3);
            chk(s_ch[b+i] == int'(ent[i%3][5:0]), "R2 channel", s_ch[b+i], int'(ent[i%3][5:0]));
            chk(s_rg[b+i] == int'(ent[i%3][7:6]), "R2 range", s_rg[b+i], int'(ent[i%3][7:6]));
            chk(s_dn[b+i] == (i == 6), "R9 done on last", int'(s_dn[b+i]), int'(i == 6));
        end
        for (int i = 1; i < 6; i++)
            chk(s_cyc[b+i+1] - s_cyc[b+i] == 12, "R3 convert spacing",
                s_cyc[b+i+1] - s_cyc[b+i], 12);
        chk(n_done - d0 == 1, "R9 one done", n_done - d0, 1);
        chk(!busy, "R9 idle after stop", int'(busy), 0);
    endtask

    task automatic t_retrig();
        int b = n_s;
        setup(3'd2, 10'd2, {4'd0, 16'd2}, {4'd0, 16'd5}, 24'd6);
        pulse_go();
        wait_n(b, 6, 600, "R6");
        for (int i = 0; i < 6; i++)
            chk(s_idx[b+i] == i % 2, "R6 slot order", s_idx[b+i], i % 2);
        chk(s_cyc[b+4] - s_cyc[b+2] == 20, "R6 scan spacing", s_cyc[b+4] - s_cyc[b+2], 20);
        chk(s_cyc[b+2] - s_cyc[b+1] > 4, "R6 waits for scan tick", s_cyc[b+2] - s_cyc[b+1], 5);
        chk(!overrun, "R8 no overrun", int'(overrun), 0);
    endtask

    task automatic t_overrun();
        int b = n_s;
        setup(3'd2, 10'd4, {4'd0, 16'd4}, {4'd0, 16'd3}, 24'd8);
        pulse_go();
        wait_n(b, 8, 800, "R8");
        chk(overrun, "R8 overrun set", int'(overrun), 1);
        idle(10);
        chk(overrun, "R8 overrun held", int'(overrun), 1);
    endtask

    task automatic t_external();
        int b = n_s;
        setup(3'd1, 10'd2, {4'd0, 16'd2}, 20'h00001, 24'd3);
        pulse_go();
        chk(!overrun, "R8 cleared by go", int'(overrun), 0);
        idle(20);
        chk(n_s == b, "R7 waits for ext_trig", n_s - b, 0);
        chk(busy, "R7 armed", int'(busy), 1);
        pulse_ext();
        wait_n(b, 3, 200, "R7");
        for (int i = 0; i < 3; i++)
            chk(s_idx[b+i] == i % 2, "R7 mode 1 order", s_idx[b+i], i % 2);
        b = n_s;
        setup(3'd4, 10'd2, {4'd0, 16'd2}, 20'h00001, 24'd4);
        pulse_go();
        pulse_ext();
        wait_n(b, 2, 200, "R7");
        idle(30);
        chk(n_s - b == 2, "R7 mode 4 waits per scan", n_s - b, 2);
        chk(busy, "R7 mode 4 still running", int'(busy), 1);
        pulse_ext();
        wait_n(b, 4, 200, "R7");
        chk(s_idx[b+2] == 0 && s_idx[b+3] == 1, "R7 mode 4 second scan", s_idx[b+3], 1);
        chk(!busy, "R7 mode 4 finished", int'(busy), 0);
    endtask

    task automatic t_len0();
        int b = n_s;
        setup(3'd0, 10'd0, {4'd0, 16'd1}, 20'h00001, 24'd3);
        pulse_go();
        wait_n(b, 3, 200, "R12");
        for (int i = 0; i < 3; i++) begin
            chk(s_idx[b+i] == 0, "R12 length 0 as 1", s_idx[b+i], 0);
            chk(s_ch[b+i] == 5, "R12 slot 0 channel", s_ch[b+i], 5);
        end
    endtask

    task automatic t_abort_ignore();
        int b = n_s;
        int c, d0;
        setup(3'd0, 10'd3, {4'd0, 16'd2}, {4'd0, 16'd1}, 24'd0);
        pulse_go();
        wait_n(b, 4, 200, "R11");
        trig_mode = 3'd2;
        pulse_go();
        wait_n(b, 8, 200, "R11");
        for (int i = 0; i < 8; i++)
            chk(s_idx[b+i] == i % 3, "R11 go while busy ignored", s_idx[b+i], i % 3);
        for (int i = 1; i < 7; i++)
            chk(s_cyc[b+i+1] - s_cyc[b+i] == 4, "R11 pacing unchanged",
                s_cyc[b+i+1] - s_cyc[b+i], 4);
        d0 = n_done;
        pulse_abort();
        chk(!busy, "R10 idle after abort", int'(busy), 0);
        c = n_s;
        idle(20);
        chk(n_s == c, "R10 no samples after abort", n_s - c, 0);
        chk(n_done == d0, "R10 no done on abort", n_done - d0, 0);
        trig_mode = 3'd5;
        pulse_go();
        idle(5);
        chk(!busy && n_s == c, "R7 mode 5 rejected", int'(busy), 0);
    endtask

    task automatic t_div0();
        int b = n_s;
        conv_sp = 1;
        setup(3'd0, 10'd2, 20'h00000, 20'h00001, 24'd2);
        pulse_go();
        wait_n(b, 2, 70000, "R4");
        chk(s_cyc[b+1] - s_cyc[b] == 65536, "R4 divider 0 period", s_cyc[b+1] - s_cyc[b], 65536);
        conv_sp = 2;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int i = 0; i < 4; i++) begin
            list_we = 1'b1; list_waddr = 9'(i); list_wdata = ent[i];
            @(negedge clk);
        end
        list_we = 1'b0;
        t_mode0();
        t_retrig();
        t_overrun();
        t_external();
        t_len0();
        t_abort_ignore();
        t_div0();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule